// File: doc/BRIEF.md
# DDR Self-Refresh Entry/Exit Sequencer

This block sits in a DDR SDRAM controller and owns the memory's low-power self-refresh mode. When the controller asserts a sleep request while the sequencer is idle, the block puts one refresh command on the command bus with the clock-enable pin driven low. It then keeps clock enable low, with the rest of the bus parked at a fixed idle pattern, for as long as the memory is asleep.

A wake request starts the exit. The block first waits until the clock-stable input is high and only then raises clock enable. It then emits NOPs for a parameterised exit window (`TXSNR` clocks) and a mode-register-set command with the DLL-reset bit set. After that it emits NOPs for `DLL_LOCK_CYC` more clocks (200 by default) so the DLL can lock. It then returns to idle and pulses a ready acknowledge. A wake request that arrives while entry is still under way is remembered and acted on once the memory is asleep. A sleep request is only taken from idle.

All request, acknowledge and status pins are plain level or pulse control signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `sr_seq_top`

## Requirements
- R1: After reset, clock enable is high, the command bus carries NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and both acknowledges are low.
- R2: A sleep request sampled in idle produces, in the next cycle, exactly one refresh command (0001) with clock enable low.
- R3: After the refresh cycle and until the exit begins, clock enable stays low, the bus carries NOP with address and bank all zero, and sleep_ack is high.
- R4: Clock enable rises only after a wake is pending and clk_stable has been sampled high. While clk_stable stays low, clock enable stays low indefinitely.
- R5: Once clock enable is high, exactly TXSNR NOP cycles follow. Then one mode-register-set command (0000) appears with bank 0 and address equal to MODE_BASE with bit DLL_BIT (8) set.
- R6: Exactly DLL_LOCK_CYC NOP cycles separate that mode-register-set command from the wake_ack cycle.
- R7: wake_ack is a single-cycle pulse in the first idle cycle after an exit and is low at all other times.
- R8: A wake request seen during the entry (refresh) cycle is held, and the exit proceeds without any further wake request.
- R9: A sleep request outside idle and a wake request in idle are ignored: no extra refresh command appears, clock enable does not change and no acknowledge is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Request to enter self refresh |
| sleep_ack | output | 1 | High while the memory is in self refresh |
| wake_req | input | 1 | Request to leave self refresh |
| wake_ack | output | 1 | One-cycle pulse when the memory is usable again |
| clk_stable | input | 1 | Memory clock has been stable long enough |
| cke | output | 1 | Clock enable toward the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (mode value during DLL reset) |
| ba | output | BA_W | Bank address |

## Verification
The bench builds the block with TXSNR = 7, DLL_LOCK_CYC = 200, ADDR_W = 13 and MODE_BASE = 0x032. With these values the exit window has an odd length that an off-by-one counter would miss. The lock wait is the full 200-cycle count, so a truncated counter shows up. The expected DLL-reset address is 0x132, which separates the reset bit from the base bits. One directed run holds clk_stable low for many cycles and checks the gate. Others raise wake during the refresh cycle, and hold sleep high through a whole exit.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ENTER     = 3'd1,
    ST_IN_SR     = 3'd2,
    ST_WAIT_CLK  = 3'd3,
    ST_XSNR_WAIT = 3'd4,
    ST_DLL_RST   = 3'd5,
    ST_DLL_LOCK  = 3'd6
  } sr_state_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;
endpackage

// File: rtl/sr_cyc_timer.sv
module sr_cyc_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sr_cmd_map.sv
module sr_cmd_map
  import sr_seq_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int DLL_BIT   = 8,
  parameter logic [ADDR_W-1:0] MODE_BASE = '0
) (
  input  sr_state_t         st,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] DLL_WORD = MODE_BASE | (ADDR_W'(1) << DLL_BIT);

  always_comb begin
    cke  = 1'b1;
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    unique case (st)
      ST_ENTER: begin
        cke = 1'b0;
        cmd = CMD_REF;
      end
      ST_IN_SR, ST_WAIT_CLK: cke = 1'b0;
      ST_DLL_RST: begin
        cmd  = CMD_MRS;
        addr = DLL_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sr_seq_top.sv
module sr_seq_top
  import sr_seq_pkg::*;
#(
  parameter int TXSNR        = 10,
  parameter int DLL_LOCK_CYC = 200,
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int DLL_BIT      = 8,
  parameter logic [ADDR_W-1:0] MODE_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  output logic              sleep_ack,
  input  logic              wake_req,
  output logic              wake_ack,
  input  logic              clk_stable,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam int MAX_CYC = (TXSNR > DLL_LOCK_CYC) ? TXSNR : DLL_LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] XSNR_LOAD = CNT_W'(TXSNR - 1);
  localparam logic [CNT_W-1:0] LOCK_LOAD = CNT_W'(DLL_LOCK_CYC - 1);

  sr_state_t        st_q, st_d;
  logic             wake_pend_q;
  logic             ack_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic [3:0]       cmd;

  // Next-state logic and timer loads
  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE:     if (sleep_req) st_d = ST_ENTER;
      ST_ENTER:    st_d = ST_IN_SR;
      ST_IN_SR:    if (wake_pend_q || wake_req) st_d = ST_WAIT_CLK;
      ST_WAIT_CLK: if (clk_stable) begin
        st_d     = ST_XSNR_WAIT;
        tmr_load = 1'b1;
        tmr_val  = XSNR_LOAD;
      end
      ST_XSNR_WAIT: if (tmr_done) st_d = ST_DLL_RST;
      ST_DLL_RST: begin
        st_d     = ST_DLL_LOCK;
        tmr_load = 1'b1;
        tmr_val  = LOCK_LOAD;
      end
      ST_DLL_LOCK: if (tmr_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      wake_pend_q <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= (st_q == ST_DLL_LOCK) && (st_d == ST_IDLE);
      if (st_q == ST_ENTER && wake_req) wake_pend_q <= 1'b1;
      else if (st_q == ST_IN_SR)        wake_pend_q <= 1'b0;
    end
  end

  sr_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  sr_cmd_map #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .DLL_BIT   (DLL_BIT),
    .MODE_BASE (MODE_BASE)
  ) u_cmd (
    .st   (st_q),
    .cke  (cke),
    .cmd  (cmd),
    .addr (addr),
    .ba   (ba)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign sleep_ack = (st_q == ST_IN_SR) || (st_q == ST_WAIT_CLK);
  assign wake_ack  = ack_q;

  p_entry_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENTER) |-> (cmd == CMD_REF && !cke));
  p_cke_low_sr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack |-> (!cke && cmd == CMD_NOP));
  p_cke_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));
  p_mrs_after_xsnr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_MRS) |-> ($past(st_q) == ST_XSNR_WAIT && $past(tmr_done)));
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack);
  p_enter_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ENTER) |-> ($past(st_q) == ST_IDLE));
endmodule

// File: tb/tb_sr_seq_top.sv
module tb_sr_seq_top;
  localparam int TXSNR   = 7;
  localparam int LOCK    = 200;
  localparam int ADDR_W  = 13;
  localparam int BA_W    = 2;
  localparam logic [ADDR_W-1:0] BASE = 13'h0032;
  localparam logic [ADDR_W-1:0] EXP_DLL = 13'h0132;
  localparam logic [3:0] NOP = 4'b0111, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, wake_req = 1'b0, clk_stable = 1'b1;
  logic sleep_ack, wake_ack, cke, cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sr_seq_top #(
    .TXSNR(TXSNR), .DLL_LOCK_CYC(LOCK), .ADDR_W(ADDR_W), .BA_W(BA_W),
    .DLL_BIT(8), .MODE_BASE(BASE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .wake_req(wake_req), .wake_ack(wake_ack), .clk_stable(clk_stable),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba)
  );

  function automatic logic [3:0] cmd_now();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    tick();
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(cmd_now() == NOP, "R1 cmd", cmd_now(), NOP);
    chk(!sleep_ack && !wake_ack, "R1 acks", {sleep_ack, wake_ack}, 0);
  endtask

  task automatic t_enter();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    chk(cmd_now() == REF, "R2 refresh cmd", cmd_now(), REF);
    chk(cke == 1'b0, "R2 cke low", cke, 0);
    tick();
    chk(cke == 1'b0 && cmd_now() == NOP, "R3 cke/cmd", {cke, cmd_now()}, {1'b0, NOP});
    chk(addr == '0 && ba == '0, "R3 addr/ba", {ba, addr}, 0);
    chk(sleep_ack == 1'b1, "R3 sleep_ack", sleep_ack, 1);
  endtask

  // Wake already requested; measure the exit. hold_sleep keeps sleep_req high.
  task automatic t_exit(input bit hold_sleep, input bit send_wake);
    int n;
    bit saw_ref;
    saw_ref = 1'b0;
    if (hold_sleep) sleep_req = 1'b1;
    if (send_wake) begin
      wake_req = 1'b1;
      tick();
      wake_req = 1'b0;
    end
    n = 0;
    while (!cke && n < 1000) begin
      if (cmd_now() == REF) saw_ref = 1'b1;
      tick();
      n++;
    end
    chk(cke == 1'b1, "R4 cke rose", cke, 1);
    n = 0;
    while (cmd_now() != MRS && n < 1000) begin
      if (cmd_now() != NOP) saw_ref = 1'b1;
      n++;
      tick();
    end
    chk(n == TXSNR, "R5 xsnr nops", n, TXSNR);
    chk(addr == EXP_DLL && ba == '0, "R5 dll addr", addr, EXP_DLL);
    tick();
    n = 0;
    while (!wake_ack && n < 1000) begin
      if (cmd_now() != NOP || !cke) saw_ref = 1'b1;
      n++;
      tick();
    end
    chk(n == LOCK, "R6 lock nops", n, LOCK);
    chk(cmd_now() == NOP && cke, "R7 idle on ack", {cke, cmd_now()}, {1'b1, NOP});
    sleep_req = 1'b0;
    tick();
    chk(!wake_ack, "R7 ack pulse", wake_ack, 0);
    chk(!saw_ref, hold_sleep ? "R9 no cmd during exit" : "R5 clean exit", saw_ref, 0);
  endtask

  task automatic t_gate();
    t_enter();
    clk_stable = 1'b0;
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (cke) begin
        chk(1'b0, "R4 cke held low", cke, 0);
        break;
      end
      tick();
    end
    chk(!cke && sleep_ack, "R4 still asleep", {cke, sleep_ack}, 2'b01);
    clk_stable = 1'b1;
    t_exit(1'b0, 1'b0);
  endtask

  task automatic t_early_wake();
    sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
    wake_req = 1'b1;
    chk(cmd_now() == REF, "R8 in entry", cmd_now(), REF);
    tick();
    wake_req = 1'b0;
    t_exit(1'b0, 1'b0);
  endtask

  task automatic t_ignored();
    wake_req = 1'b1;
    tick();
    wake_req = 1'b0;
    for (int i = 0; i < 5; i++) tick();
    chk(cke && !wake_ack && !sleep_ack && cmd_now() == NOP, "R9 wake in idle",
        {cke, wake_ack, sleep_ack}, 3'b100);
    t_enter();
    sleep_req = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (cmd_now() != NOP || cke) begin
        chk(1'b0, "R9 sleep in sr", cmd_now(), NOP);
        break;
      end
    end
    sleep_req = 1'b0;
    chk(!cke && sleep_ack, "R9 still asleep", {cke, sleep_ack}, 2'b01);
    t_exit(1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enter();
    t_exit(1'b0, 1'b1);
    t_gate();
    t_early_wake();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule